// File: doc/BRIEF.md
# Programmable Serial Character Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a line that rests high. A byte-wide control register chooses the frame shape: 5 to 8 data bits, an optional parity bit, and a short, long or extra-long stop period. The parity bit can be even or odd. It can also be stuck at a fixed level.

Software, or a neighbouring bus slave, writes a character into a one-entry holding register. The block copies that character into its shifter at the next frame boundary and sends a low start bit. The data bits follow, least significant first, then the parity bit if enabled, then the stop period. Every bit lasts sixteen pulses of an external baud tick. An active-low ready output shows when the holding register can take the next character. A transmitter-empty flag shows when nothing is waiting and nothing is on the line. A break control bit pulls the line low at once, for as long as the bit stays set.

Top module: `sertx_core`

## Requirements
- R1: After reset the control register reads as zero, `ser_out` is 1, `rdy_n` is 0 and `tx_empty` is 1. A character then sent with no control write goes out as 5 data bits, no parity and one stop bit, which takes 112 ticks.
- R2: A frame is one low start bit followed by the data bits, least significant bit first. Each bit lasts 16 `baud_tick` pulses. Control bits [1:0] set the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Only the low bits of the character are sent.
- R3: Control bit 3 set inserts one parity bit after the last data bit. When bit 3 is clear, the stop period follows the data directly.
- R4: With control bit 5 clear, control bit 4 set gives even parity and bit 4 clear gives odd parity. Parity is taken over the transmitted data bits only.
- R5: With control bits 5 and 3 set, the parity bit is fixed: 0 when bit 4 is set and 1 when bit 4 is clear, whatever the data.
- R6: Control bit 2 clear gives a stop period of 16 ticks. Bit 2 set gives 24 ticks for 5-bit words and 32 ticks for 6, 7 or 8-bit words. The time from the start of a frame to the return of `tx_empty` is 16 ticks times (1 + data bits + parity bits), plus the stop period.
- R7: While control bit 6 is set, `ser_out` is 0. This takes effect in the cycle after the control write.
- R8: `tx_empty` is 1 only when the holding register is empty and no frame is in progress.
- R9: `rdy_n` is 1 exactly while the holding register holds a character. If a character is waiting when a stop period ends, its start bit begins in the next cycle with no idle time, so consecutive start bits are exactly one frame length apart.
- R10: A write to the holding register while it is full is ignored, and the waiting character is kept.
- R11: A control write made during a frame does not change that frame. It applies from the next frame loaded onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle baud pulse; 16 pulses make one bit time |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Control byte; bit 7 is reserved |
| hold_we | input | 1 | Write strobe for the holding register |
| hold_wdata | input | 8 | Character to send |
| ser_out | output | 1 | Serial line, high when idle |
| rdy_n | output | 1 | Low when the holding register can accept a character |
| tx_empty | output | 1 | High when nothing is waiting and nothing is being sent |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse synchronous to `clk`. They also assume that the write strobes are sampled only at the clock edge and that reset is applied before any write. The stimulus drives every input at the falling clock edge and raises `baud_tick` every second cycle, so the tick counter sees both tick and no-tick cycles. Control writes are made while the line is idle or in the middle of a frame, and holding-register writes are made when the register is both empty and full.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   // Frame sequencer phases
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_PAR,
      PH_STOP
   } sertx_phase_e;

   // Decoded control byte; bit positions follow the control register layout
   typedef struct packed {
      logic       brk;        // bit 6
      logic       stick;      // bit 5
      logic       even;       // bit 4
      logic       par_en;     // bit 3
      logic       stop_long;  // bit 2
      logic [1:0] wsel;       // bits 1:0
   } sertx_cfg_t;

   function automatic sertx_cfg_t sertx_decode(input logic [6:0] raw);
      sertx_cfg_t c;
      c.brk       = raw[6];
      c.stick     = raw[5];
      c.even      = raw[4];
      c.par_en    = raw[3];
      c.stop_long = raw[2];
      c.wsel      = raw[1:0];
      return c;
   endfunction

endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
   import sertx_pkg::*;
#(
   parameter int CTRL_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CTRL_W-1:0] wdata,
   output sertx_cfg_t        cfg
);
   localparam int USED_W = $bits(sertx_cfg_t);

   logic [USED_W-1:0] ctrl_q;
   logic              ctrl_unused_hi;

   initial begin
      assert (CTRL_W >= USED_W) else $error("sertx_ctrl: CTRL_W too small");
   end

   // reserved upper bits are accepted and dropped
   assign ctrl_unused_hi = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (we)
         ctrl_q <= wdata[USED_W-1:0];
   end

   assign cfg = sertx_decode(ctrl_q);

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic              full,
   output logic [DATA_W-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else if (pop) begin
         full <= 1'b0;
      end else if (we && !full) begin
         full <= 1'b1;
         data <= wdata;
      end
   end

   // R10: a write while full leaves the stored character alone
   a_r10_keep_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (full && we && !pop) |=> (full && data == $past(data)));

   // R9: a write into an empty register always lands
   a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (!full && we) |=> (full && data == $past(wdata)));

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
   import sertx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [1:0]        wsel,
   input  logic              stop_long,
   input  logic              par_en,
   input  logic              even,
   input  logic              stick,
   input  logic              hold_full,
   input  logic [DATA_W-1:0] hold_data,
   output logic              pop,
   output logic              line,
   output logic              idle
);
   localparam int MIN_W  = DATA_W - 3;
   localparam int CNT_W  = $clog2(2 * OVERSAMPLE);
   localparam int BIT_W  = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OVERSAMPLE - 1);
   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE * 3 / 2 - 1);
   localparam logic [CNT_W-1:0] TWO_LAST  = CNT_W'(2 * OVERSAMPLE - 1);

   initial begin
      assert (MIN_W >= 1) else $error("sertx_shift: DATA_W must be at least 4");
      assert (OVERSAMPLE >= 2 && (OVERSAMPLE % 2) == 0)
         else $error("sertx_shift: OVERSAMPLE must be even and at least 2");
   end

   sertx_phase_e      ph;
   logic [DATA_W-1:0] sh;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  left;
   logic              par_q;
   logic              par_en_q;
   logic [CNT_W-1:0]  stop_last_q;

   // live frame set-up, sampled only when a character is loaded
   logic [BIT_W:0]    nbits_live;
   logic [DATA_W-1:0] keep;
   logic              par_live;
   logic [CNT_W-1:0]  stop_last_live;

   assign nbits_live = (BIT_W+1)'(MIN_W) + (BIT_W+1)'(wsel);

   for (genvar g = 0; g < DATA_W; g++) begin : g_keep
      assign keep[g] = hold_data[g] & (nbits_live > (BIT_W+1)'(g));
   end

   always_comb begin
      if (stick)
         par_live = ~even;
      else if (even)
         par_live = ^keep;
      else
         par_live = ~(^keep);
   end

   always_comb begin
      if (!stop_long)
         stop_last_live = BIT_LAST;
      else if (wsel == 2'b00)
         stop_last_live = HALF_LAST;
      else
         stop_last_live = TWO_LAST;
   end

   logic bit_done;
   logic load;

   assign bit_done = tick && (cnt == ((ph == PH_STOP) ? stop_last_q : BIT_LAST));
   assign load     = hold_full && ((ph == PH_IDLE) || (ph == PH_STOP && bit_done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph          <= PH_IDLE;
         sh          <= '0;
         cnt         <= '0;
         left        <= '0;
         par_q       <= 1'b0;
         par_en_q    <= 1'b0;
         stop_last_q <= '0;
      end else if (load) begin
         ph          <= PH_START;
         sh          <= keep;
         cnt         <= '0;
         left        <= BIT_W'(nbits_live - 1'b1);
         par_q       <= par_live;
         par_en_q    <= par_en;
         stop_last_q <= stop_last_live;
      end else if (ph != PH_IDLE && tick) begin
         if (bit_done) begin
            cnt <= '0;
            case (ph)
               PH_START: ph <= PH_DATA;
               PH_DATA: begin
                  if (left == '0) begin
                     ph <= par_en_q ? PH_PAR : PH_STOP;
                  end else begin
                     sh   <= sh >> 1;
                     left <= left - 1'b1;
                  end
               end
               PH_PAR:  ph <= PH_STOP;
               default: ph <= PH_IDLE;
            endcase
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   always_comb begin
      case (ph)
         PH_START: line = 1'b0;
         PH_DATA:  line = sh[0];
         PH_PAR:   line = par_q;
         default:  line = 1'b1;
      endcase
   end

   assign pop  = load;
   assign idle = (ph == PH_IDLE);

   // R2: a loaded character starts with a low start bit in the next cycle
   a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (ph == PH_START && line == 1'b0));

   // R2: outside the stop period the sub-bit counter never passes one bit time
   a_r2_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != PH_STOP) |-> (cnt <= BIT_LAST));

   // R3: the parity phase is only reached for frames loaded with parity on
   a_r3_par_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_PAR) |-> par_en_q);

   // R6: the stop limit is one of the three legal lengths
   a_r6_stop_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_STOP) |-> (stop_last_q == BIT_LAST || stop_last_q == HALF_LAST ||
                           stop_last_q == TWO_LAST));

   // R11: frame settings stay frozen until the next load
   a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != PH_IDLE && !load) |=> ($stable(par_en_q) && $stable(stop_last_q) &&
                                    $stable(par_q)));

endmodule

// File: rtl/sertx_core.sv
module sertx_core
   import sertx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CTRL_W     = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              hold_we,
   input  logic [DATA_W-1:0] hold_wdata,
   output logic              ser_out,
   output logic              rdy_n,
   output logic              tx_empty
);
   sertx_cfg_t        cfg;
   logic              hold_full;
   logic [DATA_W-1:0] hold_data;
   logic              pop;
   logic              line;
   logic              idle;

   sertx_ctrl #(.CTRL_W(CTRL_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctrl_we),
      .wdata (ctrl_wdata),
      .cfg   (cfg)
   );

   sertx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (hold_we),
      .wdata (hold_wdata),
      .pop   (pop),
      .full  (hold_full),
      .data  (hold_data)
   );

   sertx_shift #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (baud_tick),
      .wsel      (cfg.wsel),
      .stop_long (cfg.stop_long),
      .par_en    (cfg.par_en),
      .even      (cfg.even),
      .stick     (cfg.stick),
      .hold_full (hold_full),
      .hold_data (hold_data),
      .pop       (pop),
      .line      (line),
      .idle      (idle)
   );

   // break overrides the line immediately, independent of frame boundaries
   assign ser_out  = cfg.brk ? 1'b0 : line;
   assign rdy_n    = hold_full;
   assign tx_empty = idle && !hold_full;

   // R7: break holds the line low
   a_r7_break_low: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.brk |-> !ser_out);

   // R8: an empty transmitter leaves the line high unless a break is forced
   a_r8_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty && !cfg.brk) |-> ser_out);

   // R9: a write into a ready holding register makes it busy next cycle
   a_r9_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_we && !rdy_n) |=> rdy_n);

   // R8: the transmitter cannot be empty while a character waits
   a_r8_empty_vs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> !rdy_n);

endmodule

// File: tb/sertx_core_bench.sv
module sertx_core_bench;
   localparam int CLK_PERIOD = 10;
   localparam int BITT       = 16;
   localparam int WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       ctrl_we = 1'b0;
   logic [7:0] ctrl_wdata = '0;
   logic       hold_we = 1'b0;
   logic [7:0] hold_wdata = '0;
   logic       ser_out;
   logic       rdy_n;
   logic       tx_empty;

   int n_run  = 0;
   int n_fail = 0;
   int ticks  = 0;

   sertx_core u_sertx_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .baud_tick  (baud_tick),
      .ctrl_we    (ctrl_we),
      .ctrl_wdata (ctrl_wdata),
      .hold_we    (hold_we),
      .hold_wdata (hold_wdata),
      .ser_out    (ser_out),
      .rdy_n      (rdy_n),
      .tx_empty   (tx_empty)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // bench-side tick count, advanced on every edge that sees a tick
   always @(posedge clk) if (rst_n && baud_tick) ticks <= ticks + 1;

   initial begin
      forever begin
         @(negedge clk);
         baud_tick = ~baud_tick;
      end
   end

   // {ctrl, data, expected parity bit, stop ticks}
   localparam int NVEC = 14;
   localparam logic [22:0] VEC [NVEC] = '{
      {8'h18, 8'h5A, 1'b1, 6'd16},
      {8'h1C, 8'h55, 1'b1, 6'd24},
      {8'h08, 8'hAA, 1'b1, 6'd16},
      {8'h28, 8'h55, 1'b1, 6'd16},
      {8'h38, 8'hA5, 1'b0, 6'd16},
      {8'h00, 8'h15, 1'b0, 6'd16},
      {8'h1D, 8'h55, 1'b1, 6'd32},
      {8'h0E, 8'h55, 1'b1, 6'd32},
      {8'h1B, 8'hA5, 1'b0, 6'd16},
      {8'h0F, 8'hA5, 1'b1, 6'd32},
      {8'h07, 8'h3C, 1'b0, 6'd32},
      {8'h3B, 8'hFF, 1'b0, 6'd16},
      {8'h2A, 8'h00, 1'b1, 6'd16},
      {8'h1A, 8'h2A, 1'b1, 6'd16}
   };

   task automatic check(input string req, input int got, input int exp);
      n_run++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, got, got, exp, exp);
      end
   endtask

   task automatic wr_ctrl(input logic [7:0] v);
      @(negedge clk);
      ctrl_we = 1'b1; ctrl_wdata = v;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic wr_hold(input logic [7:0] v);
      @(negedge clk);
      hold_we = 1'b1; hold_wdata = v;
      @(negedge clk);
      hold_we = 1'b0;
   endtask

   task automatic wait_to(input int target);
      while (ticks < target) @(negedge clk);
   endtask

   task automatic wait_start(input bit need_high, output int t0);
      if (need_high) while (!ser_out) @(negedge clk);
      while (ser_out) @(negedge clk);
      t0 = ticks;
   endtask

   task automatic sample_bits(input int t0, input int nsamp, output logic [15:0] got);
      got = '0;
      for (int k = 0; k < nsamp; k++) begin
         wait_to(t0 + BITT * k + BITT / 2);
         got[k] = ser_out;
      end
   endtask

   task automatic wait_empty(input int t0, output int len);
      while (!tx_empty) @(negedge clk);
      len = ticks - t0;
   endtask

   initial begin
      int t0, t1, len, nb, pe, nsamp;
      logic [15:0] got, exp;
      logic [7:0]  c, d;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state at the ports
      check("R1 ser_out after reset", ser_out, 1);
      check("R1 rdy_n after reset", rdy_n, 0);
      check("R1 tx_empty after reset", tx_empty, 1);

      // R1: cleared control gives 5 bits, no parity, 1 stop; data 0x0B -> 1,1,0,1,0
      wr_hold(8'h0B);
      wait_start(1'b0, t0);
      sample_bits(t0, 6, got);
      check("R1 R2 default frame bits", got[5:0], 6'b01011_0);
      wait_empty(t0, len);
      check("R1 R6 default frame length", len, 112);

      // table walk: R2 R3 R4 R5 R6
      for (int i = 0; i < NVEC; i++) begin
         c = VEC[i][22:15];
         d = VEC[i][14:7];
         nb = 5 + int'(c[1:0]);
         pe = int'(c[3]);
         nsamp = 1 + nb + pe;
         exp = '0;
         for (int k = 0; k < nb; k++) exp[k+1] = d[k];
         if (pe != 0) exp[1+nb] = VEC[i][6];
         wr_ctrl(c);
         wr_hold(d);
         wait_start(1'b0, t0);
         sample_bits(t0, nsamp, got);
         check($sformatf("R2 R3 R4 R5 frame bits vec %0d", i), got, exp);
         wait_empty(t0, len);
         check($sformatf("R6 frame length vec %0d", i), len,
               BITT * nsamp + int'(VEC[i][5:0]));
      end

      // R7: break forces the line low at once, release restores it
      wr_ctrl(8'h40);
      check("R7 break low", ser_out, 0);
      check("R7 R8 break sends nothing", tx_empty, 1);
      wr_ctrl(8'h00);
      check("R7 break released", ser_out, 1);

      // R9 R10 R11 R8: back-to-back, ignored write, mid-frame control change
      wr_ctrl(8'h03);
      wr_hold(8'hC3);
      check("R9 rdy_n high while waiting", rdy_n, 1);
      check("R8 not empty while waiting", tx_empty, 0);
      wait_start(1'b0, t0);
      check("R9 rdy_n low after load", rdy_n, 0);
      wr_hold(8'h2D);
      check("R9 rdy_n high with second char", rdy_n, 1);
      wr_hold(8'h12);          // R10: ignored, register full
      wr_ctrl(8'h00);          // R11: applies to the next frame only
      sample_bits(t0, 9, got);
      check("R11 first frame keeps 8 bits", got[8:0], 9'b11000011_0);
      wait_start(1'b1, t1);
      check("R9 R11 start-to-start with no gap", t1 - t0, 160);
      sample_bits(t1, 6, got);
      check("R10 R11 second frame carries kept char", got[5:0], 6'b01101_0);
      check("R8 not empty during frame", tx_empty, 0);
      wait_empty(t1, len);
      check("R11 second frame uses new setting", len, 112);
      check("R8 empty at end", tx_empty, 1);
      check("R9 ready at end", rdy_n, 0);
      check("R8 idle line high", ser_out, 1);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog (all R): got hung run expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule